// File: doc/BRIEF.md
# NAND Command/Data Phase Sequencer

This block turns single memory-mapped requests into NAND flash bus cycles on an 8-bit pin interface. The request address carries all control for an operation, so no control registers are needed. Address bit 19 picks the phase. A command phase sends a start command byte with CLE high. It then sends a programmable number of address bytes with ALE high, and can finish with an end command byte. A data phase moves one 32-bit word as four byte cycles in either direction. It can send an end command after the data and then wait for the flash to finish its busy period. It can also release chip select once the transfer is done.

The host side is a valid/ready request port with address, write data and a write flag. A read returns its 32-bit word with a one-cycle valid pulse. Every byte cycle uses a fixed strobe of two clocks low followed by two clocks high. The data bus is driven only while the write strobe is low. A data phase that carries the ECC-block-end flag produces a one-cycle marker when it completes.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale, nand_dq_oe, rsp_valid and ecc_blk_end are low, and req_ready is high.
- R2: Address bit 19 selects the phase (0 = command, 1 = data). A command phase first issues the byte in address bits [10:3] as a write cycle with nand_cle high and nand_ale low.
- R3: In a command phase, address bits [23:21] give the number of address cycles, 0 to 7. These follow the start command as write cycles with nand_ale high. Address byte k is req_wdata[8k+7:8k] for k < 4 and 0x00 for k >= 4.
- R4: When address bit 20 is set, the byte in bits [18:11] is issued last as a write cycle with nand_cle high, in either phase. A command phase does not wait for nand_rb_n.
- R5: A data-phase write issues four write cycles carrying req_wdata bytes 0, 1, 2 and 3 in that order, with nand_cle and nand_ale low.
- R6: nand_ce_n goes low at the first accepted request. It stays low across phases unless a data phase with address bit 21 set completes, which drives it high.
- R7: Every WE# or RE# strobe is low for exactly 2 clocks. Consecutive strobes are separated by at least 2 high clocks. nand_dq_oe is high only while nand_we_n is low.
- R8: A data-phase read issues four RE# strobes and samples nand_dq_i during each. It returns the word with the first byte in bits [7:0] on rsp_rdata, with rsp_valid high for exactly one cycle.
- R9: After a data-phase end command, req_ready stays low while nand_rb_n is low. It rises only after nand_rb_n has returned high.
- R10: Address bits [31:24] have no effect on the bus cycles issued.
- R11: ecc_blk_end pulses for one cycle when a data phase with address bit 10 set completes. It never pulses for a command phase or for a data phase with bit 10 clear.
- R12: req_ready is low from the cycle after a request is accepted until the phase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_addr | input | 32 | Encoded operation address |
| req_wdata | input | 32 | Address bytes or write data |
| req_write | input | 1 | Data phase direction, 1 = write |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 32 | Read word, first byte in bits [7:0] |
| ecc_blk_end | output | 1 | One-cycle marker for completed ECC-block-last transfer |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The tests vary the address-cycle count across 0, 1 and 5. This separates the zero-cycle path, the normal byte selection, and the zero padding beyond the fourth byte. Writes and reads use words whose four bytes are all distinct, so any byte reordering shows up in the captured bus log. End commands appear in both phases while the flash model is held busy. This shows that only the data phase waits for ready/busy. Chip-select release, the ECC marker and the chip-address field are each toggled against an otherwise identical request, so that the flag's effect is the only difference.

// File: rtl/nps_pkg.sv
package nps_pkg;

    localparam int WORD_W      = 32;
    localparam int BUS_W       = 8;
    localparam int WORD_BYTES  = WORD_W / BUS_W;
    localparam int NADDR_W     = 3;
    localparam int IDX_W       = NADDR_W;

    // Address field positions the sequencer decodes
    localparam int POS_PHASE   = 19;
    localparam int POS_END_EN  = 20;
    localparam int POS_CLR_CS  = 21;
    localparam int POS_ECC_END = 10;
    localparam int LSB_END_CMD = 11;
    localparam int LSB_START   = 3;
    localparam int LSB_NADDR   = 21;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_END,
        ST_GAP,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic               data_phase;
        logic [BUS_W-1:0]   start_cmd;
        logic [NADDR_W-1:0] n_addr;
        logic               end_en;
        logic [BUS_W-1:0]   end_cmd;
        logic               clr_cs;
        logic               ecc_last;
    } op_t;

    function automatic logic [BUS_W-1:0] word_byte(
        input logic [WORD_W-1:0] w,
        input logic [IDX_W-1:0]  idx
    );
        logic [BUS_W-1:0] b;
        b = '0;
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (idx == IDX_W'(k)) b = w[k*BUS_W +: BUS_W];
        end
        return b;
    endfunction

endpackage

// File: rtl/nps_decode.sv
module nps_decode
    import nps_pkg::*;
(
    input  logic [WORD_W-1:0] addr,
    output op_t               op
);
    logic unused_addr_bits;

    always_comb begin
        op.data_phase = addr[POS_PHASE];
        op.start_cmd  = addr[LSB_START +: BUS_W];
        op.end_en     = addr[POS_END_EN];
        op.end_cmd    = addr[LSB_END_CMD +: BUS_W];
        // Field meanings depend on the phase
        op.n_addr     = addr[POS_PHASE] ? '0 : addr[LSB_NADDR +: NADDR_W];
        op.clr_cs     = addr[POS_PHASE] & addr[POS_CLR_CS];
        op.ecc_last   = addr[POS_PHASE] & addr[POS_ECC_END];
    end

    // Chip-address byte and low bits carry nothing for a single device
    assign unused_addr_bits = ^{addr[WORD_W-1:24], addr[2:0]};

endmodule

// File: rtl/nps_strobe.sv
module nps_strobe #(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic active,
    output logic sample,
    output logic last
);
    localparam int TOT = LOW_CYC + HIGH_CYC;
    localparam int CW  = (TOT > 1) ? $clog2(TOT) : 1;

    logic [CW-1:0] cnt;

    assign active = run && (cnt < CW'(LOW_CYC));
    assign sample = run && (cnt == CW'(LOW_CYC - 1));
    assign last   = run && (cnt == CW'(TOT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/nps_sync.sv
module nps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b1;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
    import nps_pkg::*;
#(
    parameter int GAP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  op_t               dec_op,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              ecc_blk_end,
    output logic              run,
    input  logic              stb_active,
    input  logic              stb_sample,
    input  logic              stb_last,
    output logic              ce_act,
    output logic              cle,
    output logic              ale,
    output logic              we_act,
    output logic              re_act,
    output logic [BUS_W-1:0]  dq_o,
    output logic              dq_oe,
    input  logic [BUS_W-1:0]  dq_i,
    input  logic              rb_ready
);
    localparam int GW = $clog2(GAP_CYC + 1);

    seq_state_e        state;
    op_t               op;
    logic [WORD_W-1:0] wdata;
    logic              wr;
    logic [IDX_W-1:0]  idx;
    logic [GW-1:0]     gap_cnt;
    logic              rd_data;

    assign req_ready   = (state == ST_IDLE);
    assign run         = (state == ST_START) || (state == ST_ADDR) ||
                         (state == ST_DATA)  || (state == ST_END);
    assign rd_data     = (state == ST_DATA) && !wr;
    assign cle         = (state == ST_START) || (state == ST_END);
    assign ale         = (state == ST_ADDR);
    assign we_act      = stb_active && !rd_data;
    assign re_act      = stb_active && rd_data;
    assign dq_oe       = we_act;
    assign rsp_valid   = (state == ST_DONE) && op.data_phase && !wr;
    assign ecc_blk_end = (state == ST_DONE) && op.ecc_last;

    always_comb begin
        dq_o = '0;
        unique case (state)
            ST_START: dq_o = op.start_cmd;
            ST_ADDR:  dq_o = (idx < IDX_W'(WORD_BYTES)) ? word_byte(wdata, idx) : '0;
            ST_DATA:  dq_o = word_byte(wdata, idx);
            ST_END:   dq_o = op.end_cmd;
            default:  dq_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op        <= '0;
            wdata     <= '0;
            wr        <= 1'b0;
            idx       <= '0;
            gap_cnt   <= '0;
            ce_act    <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (rd_data && stb_sample) begin
                for (int k = 0; k < WORD_BYTES; k++) begin
                    if (idx == IDX_W'(k)) rsp_rdata[k*BUS_W +: BUS_W] <= dq_i;
                end
            end
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op     <= dec_op;
                        wdata  <= req_wdata;
                        wr     <= req_write;
                        idx    <= '0;
                        ce_act <= 1'b1;
                        state  <= dec_op.data_phase ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (stb_last) begin
                        idx <= '0;
                        if (op.n_addr != '0) state <= ST_ADDR;
                        else if (op.end_en)  state <= ST_END;
                        else                 state <= ST_DONE;
                    end
                end
                ST_ADDR: begin
                    if (stb_last) begin
                        if (idx == op.n_addr - 1'b1) begin
                            state <= op.end_en ? ST_END : ST_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (stb_last) begin
                        if (idx == IDX_W'(WORD_BYTES - 1)) begin
                            state <= op.end_en ? ST_END : ST_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_END: begin
                    if (stb_last) begin
                        gap_cnt <= '0;
                        state   <= op.data_phase ? ST_GAP : ST_DONE;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(GAP_CYC - 1)) state <= ST_WAIT;
                    else                             gap_cnt <= gap_cnt + 1'b1;
                end
                ST_WAIT: begin
                    if (rb_ready) state <= ST_DONE;
                end
                ST_DONE: begin
                    if (op.clr_cs) ce_act <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nps_pkg::*;
#(
    parameter int GAP_CYC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYC     = 2,
    parameter int HIGH_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              ecc_blk_end,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [BUS_W-1:0]  nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [BUS_W-1:0]  nand_dq_i,
    input  logic              nand_rb_n
);
    op_t  dec_op;
    logic run, stb_active, stb_sample, stb_last;
    logic rb_ready, ce_act, we_act, re_act;

    nps_decode u_dec (
        .addr (req_addr),
        .op   (dec_op)
    );

    nps_strobe #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_stb (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .active (stb_active),
        .sample (stb_sample),
        .last   (stb_last)
    );

    nps_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk (clk),
        .rst (rst),
        .d   (nand_rb_n),
        .q   (rb_ready)
    );

    nps_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .dec_op      (dec_op),
        .req_wdata   (req_wdata),
        .req_write   (req_write),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .ecc_blk_end (ecc_blk_end),
        .run         (run),
        .stb_active  (stb_active),
        .stb_sample  (stb_sample),
        .stb_last    (stb_last),
        .ce_act      (ce_act),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .we_act      (we_act),
        .re_act      (re_act),
        .dq_o        (nand_dq_o),
        .dq_oe       (nand_dq_oe),
        .dq_i        (nand_dq_i),
        .rb_ready    (rb_ready)
    );

    assign nand_ce_n = !ce_act;
    assign nand_we_n = !we_act;
    assign nand_re_n = !re_act;

endmodule

// File: rtl/nps_checker.sv
module nps_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       ecc_blk_end,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe
);
    assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_ce_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    assert_we_low_two_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |=> !nand_we_n);

    assert_we_high_two_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |=> nand_we_n);

    assert_re_low_two_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_re_n) |=> !nand_re_n);

    assert_oe_in_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe |-> !nand_we_n);

    assert_rsp_single_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_ecc_single_R11: assert property (@(posedge clk) disable iff (rst)
        ecc_blk_end |=> !ecc_blk_end);

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind nand_phase_seq nps_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .ecc_blk_end (ecc_blk_end),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_oe  (nand_dq_oe)
);

// File: tb/nand_phase_seq_tb.sv
module nand_phase_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ecc_blk_end;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb_n = 1'b1;

    always #5 clk = ~clk;

    nand_phase_seq u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_write (req_write),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .ecc_blk_end (ecc_blk_end),
        .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
        .nand_we_n (nand_we_n), .nand_re_n (nand_re_n),
        .nand_dq_o (nand_dq_o), .nand_dq_oe (nand_dq_oe),
        .nand_dq_i (nand_dq_i), .nand_rb_n (nand_rb_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bus log, cleared per scenario
    logic [7:0] lg_byte [16];
    logic       lg_cle  [16];
    logic       lg_ale  [16];
    logic       lg_oe   [16];
    int n_we = 0, n_re = 0, rsp_cnt = 0, ecc_cnt = 0;
    logic [31:0] last_rd = '0;
    int width_err = 0, busy_err = 0;
    int busy_len = 0, busy_cnt = 0;
    bit arm_busy = 1'b0, chk_busy = 1'b0;
    logic [7:0] fbytes [4];
    int lw = 0, hw = 99, lr = 0, hr = 99;
    logic prev_we = 1'b1, prev_re = 1'b1;

    task automatic check(input string req, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // flash-side monitor and model
    always @(negedge clk) begin
        if (!rst) begin
            if (!nand_we_n) begin
                if (prev_we) begin
                    if (hw < 2) width_err++;
                    if (n_we < 16) begin
                        lg_byte[n_we] = nand_dq_o;
                        lg_cle[n_we]  = nand_cle;
                        lg_ale[n_we]  = nand_ale;
                        lg_oe[n_we]   = nand_dq_oe;
                    end
                    n_we++;
                    if (arm_busy && nand_cle) begin
                        busy_cnt = busy_len;
                        arm_busy = 1'b0;
                    end
                    lw = 1;
                end else lw++;
            end else begin
                if (!prev_we) begin
                    if (lw != 2) width_err++;
                    hw = 1;
                end else hw++;
            end
            if (!nand_re_n) begin
                if (prev_re) begin
                    if (hr < 2) width_err++;
                    nand_dq_i = fbytes[n_re % 4];
                    n_re++;
                    lr = 1;
                end else lr++;
            end else begin
                if (!prev_re) begin
                    if (lr != 2) width_err++;
                    hr = 1;
                end else hr++;
            end
            if (busy_cnt > 0) begin
                nand_rb_n = 1'b0;
                busy_cnt--;
            end else nand_rb_n = 1'b1;
            if (chk_busy && !nand_rb_n && req_ready) busy_err++;
            if (rsp_valid) begin
                rsp_cnt++;
                last_rd = rsp_rdata;
            end
            if (ecc_blk_end) ecc_cnt++;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    function automatic logic [31:0] cmd_addr(input logic [7:0] chip, input logic [7:0] start,
                                             input logic [2:0] naddr, input logic end_en,
                                             input logic [7:0] end_cmd);
        return {chip, naddr, end_en, 1'b0, end_cmd, start, 3'b000};
    endfunction

    function automatic logic [31:0] data_addr(input logic clr, input logic end_en,
                                              input logic [7:0] end_cmd, input logic ecc);
        return {8'h00, 2'b00, clr, end_en, 1'b1, end_cmd, ecc, 10'h000};
    endfunction

    task automatic clear_log();
        @(negedge clk);
        n_we = 0; n_re = 0; rsp_cnt = 0; ecc_cnt = 0;
    endtask

    task automatic do_req(input logic [31:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_write = w; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12", req_ready == 1'b0, {31'b0, req_ready}, 32'h0, "ready after accept");
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", nand_ce_n && nand_we_n && nand_re_n, {29'b0, nand_ce_n, nand_we_n, nand_re_n},
              32'h7, "strobes and ce high");
        check("R1", !nand_cle && !nand_ale && !nand_dq_oe, {29'b0, nand_cle, nand_ale, nand_dq_oe},
              32'h0, "cle ale oe low");
        check("R1", req_ready && !rsp_valid && !ecc_blk_end, {29'b0, req_ready, rsp_valid, ecc_blk_end},
              32'h4, "ready high, pulses low");
    endtask

    task automatic t_cmd_one_addr();
        clear_log();
        do_req(cmd_addr(8'h00, 8'h90, 3'd1, 1'b0, 8'h00), 32'h0000_00A5, 1'b0);
        check("R2", n_we == 2, n_we, 2, "strobe count");
        check("R2", lg_cle[0] && !lg_ale[0] && lg_byte[0] == 8'h90, {lg_cle[0], lg_ale[0], lg_byte[0]},
              {2'b10, 8'h90}, "start command");
        check("R3", !lg_cle[1] && lg_ale[1] && lg_byte[1] == 8'hA5, {lg_cle[1], lg_ale[1], lg_byte[1]},
              {2'b01, 8'hA5}, "address byte");
        check("R6", nand_ce_n == 1'b0, nand_ce_n, 0, "ce low after command phase");
    endtask

    task automatic t_cmd_five_addr_end();
        logic [7:0] exp [7];
        exp = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h30};
        clear_log();
        busy_len = 60; arm_busy = 1'b1;
        do_req(cmd_addr(8'h00, 8'h00, 3'd5, 1'b1, 8'h30), 32'h4433_2211, 1'b0);
        check("R3", n_we == 7, n_we, 7, "strobe count");
        for (int k = 0; k < 7; k++) begin
            check(k == 6 ? "R4" : "R3", lg_byte[k] == exp[k], lg_byte[k], exp[k], "byte value");
            check(k == 6 ? "R4" : "R3",
                  (lg_cle[k] == (k == 0 || k == 6)) && (lg_ale[k] == (k > 0 && k < 6)),
                  {lg_cle[k], lg_ale[k]}, {(k == 0 || k == 6), (k > 0 && k < 6)}, "latch enables");
        end
        check("R4", nand_rb_n == 1'b0, nand_rb_n, 0, "command phase finished without busy wait");
        while (!nand_rb_n) @(negedge clk);
    endtask

    task automatic t_data_write(input logic [31:0] w);
        clear_log();
        do_req(data_addr(1'b0, 1'b0, 8'h00, 1'b0), w, 1'b1);
        check("R5", n_we == 4 && n_re == 0, {n_we[15:0], n_re[15:0]}, {16'd4, 16'd0}, "strobe counts");
        for (int k = 0; k < 4; k++) begin
            check("R5", lg_byte[k] == w[8*k +: 8] && !lg_cle[k] && !lg_ale[k],
                  {lg_cle[k], lg_ale[k], lg_byte[k]}, {2'b00, w[8*k +: 8]}, "data byte");
            check("R7", lg_oe[k] == 1'b1, lg_oe[k], 1, "bus driven in write strobe");
        end
        check("R6", nand_ce_n == 1'b0, nand_ce_n, 0, "ce held without release flag");
        check("R7", nand_dq_oe == 1'b0, nand_dq_oe, 0, "bus released when idle");
    endtask

    task automatic t_data_read();
        fbytes = '{8'h5A, 8'h6B, 8'h7C, 8'h8D};
        clear_log();
        do_req(data_addr(1'b0, 1'b0, 8'h00, 1'b0), 32'h0, 1'b0);
        check("R8", n_re == 4 && n_we == 0, {n_re[15:0], n_we[15:0]}, {16'd4, 16'd0}, "strobe counts");
        check("R8", rsp_cnt == 1, rsp_cnt, 1, "single response pulse");
        check("R8", last_rd == 32'h8D7C_6B5A, last_rd, 32'h8D7C_6B5A, "read word");
        check("R11", ecc_cnt == 0, ecc_cnt, 0, "no marker without flag");
    endtask

    task automatic t_release_cs();
        clear_log();
        do_req(data_addr(1'b1, 1'b0, 8'h00, 1'b0), 32'h0102_0304, 1'b1);
        check("R6", nand_ce_n == 1'b1, nand_ce_n, 1, "ce released after flagged transfer");
        check("R6", n_we == 4, n_we, 4, "transfer completed");
    endtask

    task automatic t_data_end_busy();
        clear_log();
        busy_len = 20; arm_busy = 1'b1; chk_busy = 1'b1;
        do_req(data_addr(1'b0, 1'b1, 8'h10, 1'b0), 32'hCAFE_F00D, 1'b1);
        chk_busy = 1'b0;
        check("R9", busy_err == 0, busy_err, 0, "ready while busy");
        check("R9", nand_rb_n == 1'b1, nand_rb_n, 1, "finished after ready");
        check("R4", n_we == 5 && lg_cle[4] && lg_byte[4] == 8'h10,
              {n_we[7:0], 7'b0, lg_cle[4], lg_byte[4]}, {8'd5, 8'd1, 8'h10}, "data-phase end command");
    endtask

    task automatic t_chip_field();
        clear_log();
        do_req(cmd_addr(8'hFF, 8'h90, 3'd1, 1'b0, 8'h00), 32'h0000_00A5, 1'b0);
        check("R10", n_we == 2 && lg_byte[0] == 8'h90 && lg_byte[1] == 8'hA5,
              {n_we[15:0], lg_byte[0], lg_byte[1]}, {16'd2, 8'h90, 8'hA5}, "chip field ignored");
    endtask

    task automatic t_ecc();
        clear_log();
        do_req(data_addr(1'b0, 1'b0, 8'h00, 1'b1), 32'h1111_2222, 1'b1);
        check("R11", ecc_cnt == 1, ecc_cnt, 1, "marker on flagged data phase");
        clear_log();
        do_req(cmd_addr(8'h00, 8'h80, 3'd0, 1'b0, 8'h00), 32'h0, 1'b0);
        check("R11", ecc_cnt == 0, ecc_cnt, 0, "no marker in command phase");
        check("R3", n_we == 1 && lg_cle[0], {n_we[15:0], 15'b0, lg_cle[0]}, {16'd1, 16'd1},
              "zero address cycles");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd_one_addr();
        t_cmd_five_addr_end();
        t_data_write(32'hDEAD_BEEF);
        t_data_write(32'h0123_4567);
        t_data_read();
        t_release_cs();
        t_data_end_busy();
        t_chip_field();
        t_ecc();
        check("R7", width_err == 0, width_err, 0, "strobe widths");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule